// File: doc/BRIEF.md
# Dual-Lane Serial Read Engine

This block is the read path of a serial flash slave. After chip select falls it takes a command byte one bit per clock on lane 0. It then collects a 24-bit byte address and, in the dual-lane variant, a mode byte. It waits out a number of idle clocks and then streams memory bytes back on the data lines, one or two bits per clock. Memory is reached through an asynchronous byte read port: the engine presents an address and takes the byte in the same cycle. The address advances after every byte, so a read runs on until chip select rises.

The dual-lane address variant also carries a mode byte. A particular value in that byte arms a continuous mode. In this mode the next transaction skips the command byte and starts directly with the address and mode clocks. Sending all ones in the address and mode field is the escape sequence. It disarms the mode and returns no data, so that a host that has lost track of the slave can bring it back to command decoding.

The block runs on the serial clock, samples the lanes on the rising edge and updates its outputs on the same edge. Lane enables replace a tri-state pin: a lane is driven only while its enable is high.

Top module: `dualio_read_engine`

## Requirements
- R1: The command byte is taken most significant bit first on io_in[0], one bit per clock. 8'h0B selects the single-lane read, 8'h3B the dual-data read and 8'hBB the dual-address read. Any other code drives nothing until chip select rises.
- R2: In a single-lane read the 24 address bits arrive MSB first on io_in[0]. DUMMY_CLKS idle clocks follow, during which the lanes are ignored. Data then leaves MSB first on io_out[1], one bit per clock, with io_oe = 2'b10.
- R3: A dual-data read has the same address and idle phases. Each clock then carries two data bits: io_out[1] carries bit 7, 5, 3, 1 and io_out[0] carries bit 6, 4, 2, 0, highest pair first, with io_oe = 2'b11.
- R4: A dual-address read takes 24 address bits followed by mode bits M7..M0 in 16 clocks, two bits per clock. io_in[1] carries the odd bit and io_in[0] the even bit of each pair, highest pair first. One clock with both lanes undriven follows, and data then streams as in R3.
- R5: When M5..M4 equals 2'b10, the next transaction starts directly with the address and mode clocks of R4, with no command byte. Any other value returns the engine to command decoding.
- R6: A dual-address field of all ones (address and mode bits) returns no data and clears the continuous mode.
- R7: If busy is high on the clock that completes the address field, that transaction returns no data and the continuous mode keeps its value.
- R8: The byte address is the low ADDR_W bits of the received address. It increments after each byte and wraps from 2^ADDR_W-1 to 0. mem_rd is high in the cycle whose rising edge takes the byte at mem_addr.
- R9: io_oe is 2'b00 outside the data phase, and it falls in the same cycle that cs_n rises.
- R10: After reset, io_oe is 2'b00 and the engine expects a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| busy | input | 1 | High while a program or erase cycle runs |
| io_in | input | 2 | Lane input values |
| io_out | output | 2 | Lane output values |
| io_oe | output | 2 | Lane drive enables |
| mem_addr | output | ADDR_W | Byte address to the memory |
| mem_rd | output | 1 | Byte taken at the coming edge |
| mem_data | input | 8 | Byte returned for mem_addr |

## Verification
Each read variant is driven against a memory model whose bytes differ at every address, so a lane swap, a dropped pair or an off-by-one address shows up as a wrong byte. The idle clocks are filled with toggling lane values, which exposes any sampling during the wait. Continuous mode is tried with an arming mode value, a disarming mode value, the all-ones escape and a busy-blocked transaction. Each of these is followed by a transaction with or without a command byte, which shows whether the mode state moved. A read that starts just below the top of the array and an early chip-select rise cover the wrap and the drop of the output enables.

// File: rtl/dre_pkg.sv
package dre_pkg;
   typedef enum logic [2:0] {
      PH_OPC  = 3'd0,
      PH_ADDR = 3'd1,
      PH_WAIT = 3'd2,
      PH_DATA = 3'd3,
      PH_SKIP = 3'd4
   } phase_t;

   localparam int FIELD_W = 32;
   localparam int CNT_W   = 6;
endpackage

// File: rtl/dre_rx.sv
module dre_rx
   import dre_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               dual,
   input  logic [1:0]         io_in,
   output logic [FIELD_W-1:0] sh_nxt
);
   logic [FIELD_W-1:0] sh_q;

   always_comb begin
      if (!shift_en)
         sh_nxt = sh_q;
      else if (dual)
         sh_nxt = {sh_q[FIELD_W-3:0], io_in[1], io_in[0]};
      else
         sh_nxt = {sh_q[FIELD_W-2:0], io_in[0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_nxt;
   end
endmodule

// File: rtl/dre_ctrl.sv
module dre_ctrl
   import dre_pkg::*;
#(
   parameter int         ADDR_W     = 17,
   parameter int         DUMMY_CLKS = 8,
   parameter logic [7:0] OP_FAST    = 8'h0B,
   parameter logic [7:0] OP_DOUT    = 8'h3B,
   parameter logic [7:0] OP_DIO     = 8'hBB,
   parameter logic [1:0] KEEP_CODE  = 2'b10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n,
   input  logic               busy,
   input  logic [FIELD_W-1:0] sh_nxt,
   output logic               shift_en,
   output logic               rx_dual,
   output logic               data_dual,
   output logic               load,
   output logic               drive,
   output logic [ADDR_W-1:0]  ptr
);
   localparam logic [CNT_W-1:0] OPC_LAST   = CNT_W'(7);
   localparam logic [CNT_W-1:0] ADDR1_LAST = CNT_W'(23);
   localparam logic [CNT_W-1:0] ADDR2_LAST = CNT_W'(15);
   localparam logic [CNT_W-1:0] WAIT_LONG  = CNT_W'(DUMMY_CLKS - 1);
   localparam logic [CNT_W-1:0] WAIT_TURN  = '0;

   phase_t             phase_q;
   logic [CNT_W-1:0]   cnt_q, wait_last_q, addr_last, byte_last;
   logic               addr_dual_q, data_dual_q, cont_q;
   logic [ADDR_W-1:0]  ptr_q;
   logic               field_ones, keep;

   always_comb begin
      addr_last  = addr_dual_q ? ADDR2_LAST : ADDR1_LAST;
      byte_last  = data_dual_q ? CNT_W'(3) : CNT_W'(7);
      shift_en   = !cs_n && (phase_q == PH_OPC || phase_q == PH_ADDR);
      rx_dual    = addr_dual_q && (phase_q == PH_ADDR);
      load       = !cs_n && ((phase_q == PH_WAIT && cnt_q == wait_last_q) ||
                             (phase_q == PH_DATA && cnt_q == byte_last));
      drive      = !cs_n && (phase_q == PH_DATA);
      field_ones = &sh_nxt;
      keep       = (sh_nxt[5:4] == KEEP_CODE);
   end

   assign data_dual = data_dual_q;
   assign ptr       = ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_OPC;
         cnt_q       <= '0;
         wait_last_q <= '0;
         addr_dual_q <= 1'b0;
         data_dual_q <= 1'b0;
         cont_q      <= 1'b0;
         ptr_q       <= '0;
      end else if (cs_n) begin
         phase_q     <= cont_q ? PH_ADDR : PH_OPC;
         cnt_q       <= '0;
         addr_dual_q <= cont_q;
         data_dual_q <= cont_q;
         wait_last_q <= WAIT_TURN;
      end else begin
         case (phase_q)
            PH_OPC: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == OPC_LAST) begin
                  cnt_q <= '0;
                  if (sh_nxt[7:0] == OP_FAST || sh_nxt[7:0] == OP_DOUT) begin
                     phase_q     <= PH_ADDR;
                     addr_dual_q <= 1'b0;
                     data_dual_q <= (sh_nxt[7:0] == OP_DOUT);
                     wait_last_q <= WAIT_LONG;
                  end else if (sh_nxt[7:0] == OP_DIO) begin
                     phase_q     <= PH_ADDR;
                     addr_dual_q <= 1'b1;
                     data_dual_q <= 1'b1;
                     wait_last_q <= WAIT_TURN;
                  end else begin
                     phase_q <= PH_SKIP;
                  end
               end
            end
            PH_ADDR: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == addr_last) begin
                  cnt_q <= '0;
                  if (addr_dual_q && field_ones) begin
                     cont_q  <= 1'b0;
                     phase_q <= PH_SKIP;
                  end else if (busy) begin
                     phase_q <= PH_SKIP;
                  end else if (addr_dual_q) begin
                     cont_q  <= keep;
                     ptr_q   <= sh_nxt[8 +: ADDR_W];
                     phase_q <= PH_WAIT;
                  end else begin
                     ptr_q   <= sh_nxt[ADDR_W-1:0];
                     phase_q <= PH_WAIT;
                  end
               end
            end
            PH_WAIT, PH_DATA: begin
               cnt_q <= cnt_q + 1'b1;
               if (load) begin
                  cnt_q   <= '0;
                  phase_q <= PH_DATA;
                  ptr_q   <= ptr_q + 1'b1;
               end
            end
            default: phase_q <= PH_SKIP;
         endcase
      end
   end

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DATA && load) |=> ptr_q == ADDR_W'($past(ptr_q) + 1'b1)); // R8
   AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SKIP && !cs_n) |=> phase_q == PH_SKIP); // R7
   AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(phase_q == PH_ADDR && !cs_n) |=> $stable(cont_q)); // R5
endmodule

// File: rtl/dre_tx.sv
module dre_tx (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       drive,
   input  logic       dual,
   input  logic [7:0] mem_data,
   output logic [1:0] io_out,
   output logic [1:0] io_oe
);
   logic [7:0] dout_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dout_q <= '0;
      else if (load)   dout_q <= mem_data;
      else if (drive)  dout_q <= dual ? {dout_q[5:0], 2'b00} : {dout_q[6:0], 1'b0};
   end

   for (genvar l = 0; l < 2; l++) begin : g_lane
      if (l == 1) begin : g_odd
         assign io_out[l] = dout_q[7];
         assign io_oe[l]  = drive;
      end else begin : g_even
         assign io_out[l] = dual & dout_q[6];
         assign io_oe[l]  = drive & dual;
      end
   end

   AST_LANE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
      io_oe != 2'b01); // R2
endmodule

// File: rtl/dualio_read_engine.sv
module dualio_read_engine
   import dre_pkg::*;
#(
   parameter int         ADDR_W     = 17,
   parameter int         DUMMY_CLKS = 8,
   parameter logic [7:0] OP_FAST    = 8'h0B,
   parameter logic [7:0] OP_DOUT    = 8'h3B,
   parameter logic [7:0] OP_DIO     = 8'hBB,
   parameter logic [1:0] KEEP_CODE  = 2'b10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              busy,
   input  logic [1:0]        io_in,
   output logic [1:0]        io_out,
   output logic [1:0]        io_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [7:0]        mem_data
);
   if (ADDR_W < 8 || ADDR_W > 24) begin : g_bad_addr
      $error("ADDR_W must lie in 8..24");
   end
   if (DUMMY_CLKS < 1 || DUMMY_CLKS > 32) begin : g_bad_wait
      $error("DUMMY_CLKS must lie in 1..32");
   end

   logic [FIELD_W-1:0] sh_nxt;
   logic shift_en, rx_dual, data_dual, load, drive;

   dre_rx u_rx (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .dual(rx_dual),
      .io_in(io_in), .sh_nxt(sh_nxt)
   );

   dre_ctrl #(
      .ADDR_W(ADDR_W), .DUMMY_CLKS(DUMMY_CLKS), .OP_FAST(OP_FAST),
      .OP_DOUT(OP_DOUT), .OP_DIO(OP_DIO), .KEEP_CODE(KEEP_CODE)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(busy), .sh_nxt(sh_nxt),
      .shift_en(shift_en), .rx_dual(rx_dual), .data_dual(data_dual),
      .load(load), .drive(drive), .ptr(mem_addr)
   );

   dre_tx u_tx (
      .clk(clk), .rst_n(rst_n), .load(load), .drive(drive), .dual(data_dual),
      .mem_data(mem_data), .io_out(io_out), .io_oe(io_oe)
   );

   assign mem_rd = load;

   AST_OE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (io_oe != 2'b00) |-> !cs_n); // R9
endmodule

// File: tb/tb_dualio_read_engine.sv
`timescale 1ns/1ps
module tb_dualio_read_engine;
   localparam int AW = 17;

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, busy = 1'b0;
   logic [1:0] io_in = 2'b00, io_out, io_oe;
   logic [AW-1:0] mem_addr;
   logic mem_rd;
   logic [7:0] mem_data;
   int n_chk = 0, n_err = 0;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] memf(input logic [AW-1:0] a);
      return (a[7:0] * 8'd7 + 8'h5A) ^ a[15:8] ^ {7'd0, a[16]};
   endfunction
   assign mem_data = memf(mem_addr);

   dualio_read_engine #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(busy), .io_in(io_in),
      .io_out(io_out), .io_oe(io_oe), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_data(mem_data)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input logic i1, input logic i0);
      io_in = {i1, i0};
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic deselect();
      cs_n = 1'b1;
      #1 check(io_oe == 2'b00, "R9 oe off at deselect", io_oe, 0);
      tick(0, 0);
      tick(0, 0);
   endtask

   task automatic send_op(input logic [7:0] op);
      for (int k = 7; k >= 0; k--) tick(0, op[k]);
   endtask

   task automatic send_addr1(input logic [23:0] a);
      for (int k = 23; k >= 0; k--) tick(0, a[k]);
   endtask

   task automatic send_addr2(input logic [23:0] a, input logic [7:0] m);
      logic [31:0] v = {a, m};
      for (int k = 15; k >= 0; k--) tick(v[2*k+1], v[2*k]);
   endtask

   task automatic idle(input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         check(io_oe == 2'b00, tag, io_oe, 0);
         tick(k[0], ~k[0]);
      end
   endtask

   task automatic recv(input bit dual, input logic [AW-1:0] start, input int nb, input string tag);
      for (int b = 0; b < nb; b++) begin
         logic [7:0] got = '0;
         logic [AW-1:0] a = AW'(start + b);
         for (int k = 0; k < (dual ? 4 : 8); k++) begin
            check(io_oe == (dual ? 2'b11 : 2'b10), {tag, " lane enables"}, io_oe, dual ? 3 : 2);
            got = dual ? {got[5:0], io_out[1], io_out[0]} : {got[6:0], io_out[1]};
            if (k == (dual ? 3 : 7)) begin
               check(mem_rd && mem_addr == AW'(a + 1), "R8 next byte fetch", {mem_rd, 7'd0, 7'd0, mem_addr}, {8'h80, 7'd0, AW'(a + 1)});
            end
            tick(k[1], k[0]);
         end
         check(got == memf(a), tag, got, memf(a));
      end
   endtask

   task automatic t_reset();
      check(io_oe == 2'b00 && !mem_rd, "R10 reset state", {io_oe, mem_rd}, 0);
   endtask

   task automatic t_fast();
      cs_n = 0; send_op(8'h0B); send_addr1(24'h001234); idle(8, "R2 dummy undriven");
      recv(0, 17'h01234, 3, "R2 single lane data"); deselect();
   endtask

   task automatic t_dout_wrap();
      cs_n = 0; send_op(8'h3B); send_addr1(24'h01FFFE); idle(8, "R3 dummy undriven");
      recv(1, 17'h1FFFE, 4, "R3 R8 dual data across wrap"); deselect();
   endtask

   task automatic t_dio_normal();
      cs_n = 0; send_op(8'hBB); send_addr2(24'h000ABC, 8'h00); idle(1, "R4 turnaround");
      recv(1, 17'h00ABC, 2, "R4 dual address read"); deselect();
      cs_n = 0; send_op(8'hBB); send_addr2(24'h015001, 8'h30); idle(1, "R4 turnaround");
      recv(1, 17'h15001, 1, "R5 opcode still needed"); deselect();
   endtask

   task automatic t_cont();
      cs_n = 0; send_op(8'hBB); send_addr2(24'h002200, 8'h20); idle(1, "R4 turnaround");
      recv(1, 17'h02200, 2, "R5 arming read"); deselect();
      cs_n = 0; send_addr2(24'h003300, 8'hA5); idle(1, "R5 turnaround");
      recv(1, 17'h03300, 2, "R5 read without opcode"); deselect();
      cs_n = 0; send_addr2(24'h004400, 8'h30); idle(1, "R5 turnaround");
      recv(1, 17'h04400, 1, "R5 disarming read"); deselect();
      cs_n = 0; send_op(8'hBB); send_addr2(24'h005500, 8'h00); idle(1, "R5 turnaround");
      recv(1, 17'h05500, 1, "R5 opcode after disarm"); deselect();
   endtask

   task automatic t_escape();
      cs_n = 0; send_op(8'hBB); send_addr2(24'h006600, 8'h20); idle(1, "R4 turnaround");
      recv(1, 17'h06600, 1, "R6 arming read"); deselect();
      cs_n = 0; send_addr2(24'hFFFFFF, 8'hFF); idle(10, "R6 escape returns no data"); deselect();
      cs_n = 0; send_op(8'h0B); send_addr1(24'h000777); idle(8, "R6 dummy");
      recv(0, 17'h00777, 1, "R6 commands decoded after escape"); deselect();
   endtask

   task automatic t_bad_opcode();
      cs_n = 0; send_op(8'h03); idle(40, "R1 unknown opcode drives nothing"); deselect();
   endtask

   task automatic t_busy();
      busy = 1; cs_n = 0; send_op(8'h0B); send_addr1(24'h000100);
      busy = 0; idle(16, "R7 busy read ignored"); deselect();
      cs_n = 0; send_op(8'hBB); send_addr2(24'h008800, 8'h20); idle(1, "R4 turnaround");
      recv(1, 17'h08800, 1, "R7 arming read"); deselect();
      busy = 1; cs_n = 0; send_addr2(24'h009900, 8'h00);
      busy = 0; idle(8, "R7 busy continuous read ignored"); deselect();
      cs_n = 0; send_addr2(24'h00AA00, 8'h00); idle(1, "R7 turnaround");
      recv(1, 17'h0AA00, 1, "R7 mode kept after busy"); deselect();
   endtask

   task automatic t_abort();
      cs_n = 0; send_op(8'h0B); send_addr1(24'h000040); idle(8, "R9 dummy");
      recv(0, 17'h00040, 1, "R9 first byte");
      tick(0, 0); tick(0, 0); tick(0, 0);
      deselect();
      cs_n = 0; send_op(8'h3B); send_addr1(24'h000050); idle(8, "R9 dummy");
      recv(1, 17'h00050, 1, "R9 read after abort"); deselect();
   endtask

   initial begin
      #100_000;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      tick(0, 0);
      t_reset();
      t_fast();
      t_dout_wrap();
      t_dio_normal();
      t_cont();
      t_escape();
      t_bad_opcode();
      t_busy();
      t_abort();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule